// File: doc/BRIEF.md
# Sized Shift and Rotate Unit with Carry Insertion

This execution unit takes a 64-bit source and shifts or rotates it within an operand field of 1, 2, 4 or 8 bytes. Seven operations are offered: left shift, logical right shift, arithmetic right shift, plain rotates in both directions, and rotates in both directions that pass through a carry bit supplied by the caller. The amount comes either from a second register operand or from an 8-bit immediate. It is masked to a width that depends on the operand size.

The field result is written back into the previous destination value according to the operand size. A one-cycle strobe marks each result. Every rotate whose masked count is zero leaves the whole destination untouched. The carry-out and other status flags are produced elsewhere.

Top module: `shrot_unit`

## Requirements
- R1: The effective count is the low 6 bits of the amount operand when `size_code` is 3 (8 bytes), and the low 5 bits for any other size. The amount operand is `imm8` when `use_imm` is 1 and `src2` otherwise; the bits above the mask are ignored.
- R2: `op_code` 0 shifts the W-bit field of `src1` left (W = 8, 16, 32, 64 for `size_code` 0..3) and fills with zeros. A count of W or more yields a zero field.
- R3: `op_code` 1 shifts the field right and fills the vacated upper bits with zeros.
- R4: `op_code` 2 shifts the field right and fills the vacated upper bits with the field's bit W-1.
- R5: For `op_code` 3, 4, 5 or 6 with an effective count of 0, `result` equals `old_dest` in all 64 bits.
- R6: `op_code` 3 rotates the field right and `op_code` 4 rotates it left, each by the effective count modulo W.
- R7: `op_code` 5 rotates the (W+1)-bit value {`carry_in`, field} right by the count modulo W+1 and keeps the low W bits. For counts 1..W, `carry_in` lands at bit W-count and the source bits from position count upward fill the bits below it.
- R8: `op_code` 6 rotates {`carry_in`, field} left by the count modulo W+1 and keeps the low W bits. For counts 1..W, `carry_in` lands at bit count-1 and the top count-1 source bits fill the bits below it.
- R9: Size-based write-back: for 1- and 2-byte sizes, the bits of `old_dest` above the field are kept. For 4 bytes, bits 63:32 are zero. For 8 bytes, the field is the whole result.
- R10: `op_code` 7 is a no-operation, and `result` equals `old_dest`.
- R11: `result` and `out_valid` are registered with one cycle of latency. `out_valid` follows `in_valid`, and `result` holds its value while `in_valid` is low. Reset (synchronous, active high) clears both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation request this cycle |
| op_code | input | 3 | Operation select (see R2..R10) |
| size_code | input | 2 | Operand size: 0=1B, 1=2B, 2=4B, 3=8B |
| use_imm | input | 1 | Take the amount from `imm8` instead of `src2` |
| src1 | input | 64 | Value to shift or rotate |
| src2 | input | 64 | Register amount operand |
| imm8 | input | 8 | Immediate amount operand |
| carry_in | input | 1 | Carry bit for the through-carry rotates |
| old_dest | input | 64 | Prior destination value for write-back |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| result | output | 64 | Merged destination value |

## Verification
Every operation code and every size is swept across all 64 count values. This separates the count masking at 32 for narrow sizes, the wrap-around of the 1- and 2-byte rotates, and the count-0 and count-1 rotate edges. Two source patterns are used:
- The first has the sign bit set in every field width, which exposes sign-fill errors.
- The second mixes field signs.

The amount is taken once from the register operand, with unrelated high bits set, and once from the immediate, with bits 7:6 set. This shows whether either path leaks bits past the mask. The carry input and the old destination change from one vector to the next, so a wrong carry position or a wrong write-back rule shows up as a value mismatch rather than staying masked.

// File: rtl/shrot_pkg.sv
package shrot_pkg;

  typedef enum logic [2:0] {
    OP_SHL = 3'd0,
    OP_SHR = 3'd1,
    OP_SAR = 3'd2,
    OP_ROR = 3'd3,
    OP_ROL = 3'd4,
    OP_RCR = 3'd5,
    OP_RCL = 3'd6,
    OP_NOP = 3'd7
  } shrot_op_e;

  function automatic logic is_rotate(shrot_op_e op);
    return (op == OP_ROR) || (op == OP_ROL) || (op == OP_RCR) || (op == OP_RCL);
  endfunction

endpackage

// File: rtl/shrot_count.sv
module shrot_count #(
  parameter int DATA_W = 64,
  parameter int IMM_W  = 8,
  parameter int NSIZE  = 4,
  parameter int SZ_W   = 2,
  parameter int CNT_W  = 6
) (
  input  logic [SZ_W-1:0]   size_i,
  input  logic              use_imm_i,
  input  logic [DATA_W-1:0] src2_i,
  input  logic [IMM_W-1:0]  imm_i,
  output logic [CNT_W-1:0]  cnt_o
);
  localparam logic [SZ_W-1:0] FULL_SZ = SZ_W'(NSIZE - 1);

  logic [CNT_W-1:0] raw_cnt;

  always_comb begin
    raw_cnt = use_imm_i ? imm_i[CNT_W-1:0] : src2_i[CNT_W-1:0];
    cnt_o   = raw_cnt;
    // narrow operand sizes drop the top count bit
    if (size_i != FULL_SZ) cnt_o[CNT_W-1] = 1'b0;
  end
endmodule

// File: rtl/shrot_lane.sv
module shrot_lane
  import shrot_pkg::*;
#(
  parameter int LW    = 8,
  parameter int CNT_W = 6
) (
  input  shrot_op_e        op_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [LW-1:0]    src_i,
  input  logic             cf_i,
  output logic [LW-1:0]    res_o
);
  localparam int AW = CNT_W + 1;
  localparam logic [AW-1:0] MOD_PLAIN = AW'(LW);
  localparam logic [AW-1:0] MOD_CARRY = AW'(LW + 1);

  logic [AW-1:0]     cnt_x;
  logic [AW-1:0]     rot_n;
  logic [AW-1:0]     rotc_n;
  logic [2*LW-1:0]   dup;
  logic [2*LW+1:0]   dupc;
  logic [LW-1:0]     ror_f, rol_f, rcr_f, rcl_f, sar_f;

  always_comb begin
    cnt_x  = {1'b0, cnt_i};
    rot_n  = cnt_x % MOD_PLAIN;
    rotc_n = cnt_x % MOD_CARRY;
    dup    = {src_i, src_i};
    dupc   = {cf_i, src_i, cf_i, src_i};
    ror_f  = LW'(dup >> rot_n);
    rol_f  = LW'((dup << rot_n) >> LW);
    rcr_f  = LW'(dupc >> rotc_n);
    rcl_f  = LW'((dupc << rotc_n) >> (LW + 1));
    sar_f  = LW'($signed(src_i) >>> cnt_i);
  end

  always_comb begin
    unique case (op_i)
      OP_SHL:  res_o = src_i << cnt_i;
      OP_SHR:  res_o = src_i >> cnt_i;
      OP_SAR:  res_o = sar_f;
      OP_ROR:  res_o = ror_f;
      OP_ROL:  res_o = rol_f;
      OP_RCR:  res_o = rcr_f;
      OP_RCL:  res_o = rcl_f;
      default: res_o = src_i;
    endcase
  end
endmodule

// File: rtl/shrot_merge.sv
module shrot_merge #(
  parameter int DATA_W = 64,
  parameter int NSIZE  = 4,
  parameter int SZ_W   = 2
) (
  input  logic [SZ_W-1:0]   size_i,
  input  logic              keep_i,
  input  logic [DATA_W-1:0] old_i,
  input  logic [DATA_W-1:0] field_i,
  output logic [DATA_W-1:0] res_o
);
  logic [DATA_W-1:0] by_size [NSIZE];

  for (genvar g = 0; g < NSIZE; g++) begin : g_sz
    localparam int LW = 8 << g;
    if (g == NSIZE - 1) begin : g_full
      assign by_size[g] = field_i;
    end else if (g == NSIZE - 2) begin : g_zext
      assign by_size[g] = {{(DATA_W-LW){1'b0}}, field_i[LW-1:0]};
    end else begin : g_keep
      assign by_size[g] = {old_i[DATA_W-1:LW], field_i[LW-1:0]};
    end
  end

  assign res_o = keep_i ? old_i : by_size[size_i];
endmodule

// File: rtl/shrot_unit.sv
module shrot_unit
  import shrot_pkg::*;
#(
  parameter  int DATA_W = 64,
  parameter  int IMM_W  = 8,
  localparam int NSIZE  = $clog2(DATA_W / 8) + 1,
  localparam int SZ_W   = $clog2(NSIZE)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [2:0]        op_code,
  input  logic [SZ_W-1:0]   size_code,
  input  logic              use_imm,
  input  logic [DATA_W-1:0] src1,
  input  logic [DATA_W-1:0] src2,
  input  logic [IMM_W-1:0]  imm8,
  input  logic              carry_in,
  input  logic [DATA_W-1:0] old_dest,
  output logic              out_valid,
  output logic [DATA_W-1:0] result
);
  localparam int CNT_W = $clog2(DATA_W);
  localparam logic [SZ_W-1:0] FULL_SZ = SZ_W'(NSIZE - 1);
  localparam logic [SZ_W-1:0] ZEXT_SZ = SZ_W'(NSIZE - 2);

  shrot_op_e         op_e;
  logic [CNT_W-1:0]  eff_cnt;
  logic [DATA_W-1:0] lane_res [NSIZE];
  logic [DATA_W-1:0] field;
  logic              keep;
  logic [DATA_W-1:0] merged;

  assign op_e = shrot_op_e'(op_code);

  shrot_count #(
    .DATA_W(DATA_W), .IMM_W(IMM_W), .NSIZE(NSIZE), .SZ_W(SZ_W), .CNT_W(CNT_W)
  ) u_count (
    .size_i   (size_code),
    .use_imm_i(use_imm),
    .src2_i   (src2),
    .imm_i    (imm8),
    .cnt_o    (eff_cnt)
  );

  for (genvar g = 0; g < NSIZE; g++) begin : g_lane
    localparam int LW = 8 << g;
    logic [LW-1:0] lane_out;
    shrot_lane #(.LW(LW), .CNT_W(CNT_W)) u_lane (
      .op_i (op_e),
      .cnt_i(eff_cnt),
      .src_i(src1[LW-1:0]),
      .cf_i (carry_in),
      .res_o(lane_out)
    );
    assign lane_res[g] = DATA_W'(lane_out);
  end

  assign field = lane_res[size_code];
  assign keep  = (is_rotate(op_e) && (eff_cnt == '0)) || (op_e == OP_NOP);

  shrot_merge #(.DATA_W(DATA_W), .NSIZE(NSIZE), .SZ_W(SZ_W)) u_merge (
    .size_i (size_code),
    .keep_i (keep),
    .old_i  (old_dest),
    .field_i(field),
    .res_o  (merged)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) result <= merged;
    end
  end

  AST_NARROW_COUNT: assert property (@(posedge clk) disable iff (rst)
    (size_code != FULL_SZ) |-> (eff_cnt < CNT_W'(DATA_W / 2))); // R1

  AST_ROTATE_ZERO_HOLD: assert property (@(posedge clk) disable iff (rst)
    (in_valid && is_rotate(op_e) && eff_cnt == '0) |=> (result == $past(old_dest))); // R5

  AST_NOP_HOLD: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_e == OP_NOP) |=> (result == $past(old_dest))); // R10

  AST_DWORD_ZEXT: assert property (@(posedge clk) disable iff (rst)
    (in_valid && size_code == ZEXT_SZ && !keep) |=> (result[DATA_W-1:DATA_W/2] == '0)); // R9

  AST_BYTE_UPPER_KEEP: assert property (@(posedge clk) disable iff (rst)
    (in_valid && size_code == '0) |=> (result[DATA_W-1:8] == $past(old_dest[DATA_W-1:8]))); // R9

  AST_VALID_FOLLOW: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid); // R11

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(result)); // R11
endmodule

// File: tb/shrot_unit_test.sv
`timescale 1ns/1ps
module shrot_unit_test;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [2:0]  op_code;
  logic [1:0]  size_code;
  logic        use_imm;
  logic [63:0] src1, src2, old_dest;
  logic [7:0]  imm8;
  logic        carry_in;
  logic        out_valid;
  logic [63:0] result;

  int n_checks = 0;
  int n_fail   = 0;

  always #2.5 clk = ~clk;

  shrot_unit uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_code(op_code),
    .size_code(size_code), .use_imm(use_imm), .src1(src1), .src2(src2),
    .imm8(imm8), .carry_in(carry_in), .old_dest(old_dest),
    .out_valid(out_valid), .result(result)
  );

  function automatic logic [63:0] model(int op, int sz, logic [63:0] amt,
                                        logic [63:0] x, bit cf, logic [63:0] od);
    int w = 8 << sz;
    int c = int'(amt & ((sz == 3) ? 64'd63 : 64'd31));
    int r, idx;
    logic [63:0] f = '0;
    logic [63:0] msk;
    if (op == 7) return od;                              // R10
    if (op >= 3 && op <= 6 && c == 0) return od;         // R5
    for (int j = 0; j < w; j++) begin
      case (op)
        0: f[j] = (j >= c) ? x[j-c] : 1'b0;
        1: f[j] = (j + c < w) ? x[j+c] : 1'b0;
        2: f[j] = (j + c < w) ? x[j+c] : x[w-1];
        3: begin r = c % w; f[j] = x[(j + r) % w]; end
        4: begin r = c % w; f[j] = x[(j - r + w) % w]; end
        5: begin r = c % (w + 1); idx = (j + r) % (w + 1);
             f[j] = (idx == w) ? cf : x[idx]; end
        default: begin r = c % (w + 1); idx = (j - r + w + 1) % (w + 1);
             f[j] = (idx == w) ? cf : x[idx]; end
      endcase
    end
    if (sz >= 2) return f;                               // R9
    msk = (64'd1 << w) - 64'd1;
    return (od & ~msk) | f;
  endfunction

  function automatic string op_tag(int op, int c);
    if (op == 7) return "R10";
    if (op >= 3 && c == 0) return "R5";
    case (op)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      3, 4: return "R6";
      5: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic check64(string tag, logic [63:0] act, logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  initial begin
    #1000000;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [63:0] amt, held, x, od, expv;
    rst = 1'b1; in_valid = 1'b0; op_code = '0; size_code = '0; use_imm = 1'b0;
    src1 = '0; src2 = '0; imm8 = '0; carry_in = 1'b0; old_dest = '0;
    repeat (3) @(negedge clk);
    // R11 reset state
    check64("R11 reset out_valid", 64'(out_valid), 64'd0);
    check64("R11 reset result", result, 64'd0);
    rst = 1'b0;

    for (int pat = 0; pat < 2; pat++)
      for (int op = 0; op < 8; op++)
        for (int sz = 0; sz < 4; sz++)
          for (int c = 0; c < 64; c++) begin
            x  = pat ? 64'h0123_4567_89AB_6D3C : 64'hF0E1_D2C3_B4A5_9687;
            od = 64'hA5A5_5A5A_C3C3_3C3C ^ {32'(c * 977), 32'(op * 131 + sz)};
            in_valid = 1'b1; op_code = 3'(op); size_code = 2'(sz);
            src1 = x; old_dest = od; carry_in = (c[0] ^ pat[0]);
            if (pat == 0) begin
              // R1 register amount with unrelated high bits
              use_imm = 1'b0;
              src2 = 64'hDEAD_BEEF_0000_0000 | 64'(c + 64 * (op % 4));
              imm8 = 8'hFF;
              amt = src2;
            end else begin
              // R1 immediate amount with bits 7:6 set, register ignored
              use_imm = 1'b1;
              imm8 = 8'(c) | 8'hC0;
              src2 = '1;
              amt = 64'(imm8);
            end
            expv = model(op, sz, amt, x, carry_in, od);
            @(negedge clk);
            check64($sformatf("%s R9%s op=%0d sz=%0d c=%0d", op_tag(op, c),
                              pat ? " R1" : "", op, sz, c), result, expv);
            check64("R11 out_valid", 64'(out_valid), 64'd1);
          end

    // R11 idle: result holds, strobe drops
    held = result;
    in_valid = 1'b0; op_code = 3'd0; src1 = '1; old_dest = '0; imm8 = 8'd3;
    @(negedge clk);
    check64("R11 idle out_valid", 64'(out_valid), 64'd0);
    check64("R11 idle hold", result, held);
    @(negedge clk);
    check64("R11 idle hold 2", result, held);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule